// File: doc/BRIEF.md
# Rotate and Mask Unit

This block rotates a 64-bit operand left and then selects bits of the rotated value through a generated mask. Bits outside the mask come either from zero or, in insert mode, from the previous destination value. It is purely combinational. The execute stage feeds it the source operand, the old destination, a register-supplied shift amount and the low 16 bits of the instruction word. A 64-bit flag picks the doubleword family and a two-bit kind selects insert, immediate-shift or register-shift behaviour.

In word mode the low 32 bits of the source are copied into both halves before the 64-bit rotate, so each half holds the 32-bit rotation. The word mask is built from a begin and an end index. It wraps around when the end index is below the begin index, and in that case the upper half of the mask is all ones. Doubleword forms use 6-bit indices and one of four mask shapes. Encodings the unit does not support raise an illegal flag.

Top module: `rotmask_unit`

## Requirements
- R1: With `dw_i`=0 and `kind_i`=1 (immediate), the result is the 64-bit left rotation of {src[31:0],src[31:0]} by the shift, ANDed with the word mask. Field positions are fixed: shift in `fld_i[15:11]`, begin index in `fld_i[10:6]`, end index in `fld_i[5:1]`. Index 0 is the most significant bit of the 32-bit word.
- R2: The word mask sets word bits begin..end when end >= begin, and the upper 32 bits of the mask are then zero. When end < begin the mask sets bits 0..end and begin..31, and the upper 32 bits are all ones.
- R3: With `dw_i`=0 and `kind_i`=0 (insert), the result is (old AND NOT mask) OR (rotated AND mask), using the R1 fields.
- R4: With `dw_i`=0 and `kind_i`=2 (register), the shift is `shreg_i[4:0]`. The higher bits of `shreg_i` have no effect.
- R5: With `dw_i`=1, the 6-bit begin index is {`fld_i[5]`,`fld_i[10:6]`}. The immediate shift is {`fld_i[1]`,`fld_i[15:11]`}. Index 0 is bit 63.
- R6: With `dw_i`=1 and `kind_i`=1, the sub-mode is `fld_i[3:2]`. Code 0 keeps bits begin..63 (clear-left). Code 1 keeps bits 0..begin (clear-right). Code 2 keeps bits begin..(63-shift), wrapping when that end is below begin. Code 3 inserts under the code 2 mask.
- R7: With `dw_i`=1 and `kind_i`=2, the shift is `shreg_i[5:0]` and the sub-mode is `fld_i[3:1]`. Only code 0 (clear-left) and code 1 (clear-right) are legal.
- R8: A shift of zero leaves the rotated value equal to the (duplicated, in word mode) input. A full mask therefore returns the input unchanged.
- R9: `illegal_o` is 1 in these cases: `kind_i`=3, `dw_i`=1 with `kind_i`=0, or a register doubleword sub-mode code of 2..7. When `illegal_o` is 1, `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dw_i | input | 1 | 1 selects doubleword forms, 0 word forms |
| kind_i | input | 2 | 0 insert, 1 immediate shift, 2 register shift, 3 unsupported |
| fld_i | input | 16 | Low instruction bits carrying shift, indices and sub-mode |
| src_i | input | 64 | Value to rotate |
| dst_old_i | input | 64 | Previous destination, merged in insert modes |
| shreg_i | input | 64 | Register supplying the shift amount |
| result_o | output | 64 | Rotated and masked result |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
An all-ones source makes the result equal to the mask itself. This exposes contiguous versus wrapped word masks, including whether the upper half is set. Sources with a distinct value in every byte show the rotate direction and the word duplication. An old destination that differs from the source separates insert from clear behaviour. Register shift values with junk in their high bits confirm that only five or six bits are used. A pseudo-random sweep against an independent bit-by-bit model covers the remaining field combinations.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);

  typedef enum logic [1:0] {
    RK_INS = 2'd0,
    RK_IMM = 2'd1,
    RK_REG = 2'd2,
    RK_BAD = 2'd3
  } rm_kind_e;

  typedef enum logic [1:0] {
    MS_WORD  = 2'd0,
    MS_LEFT  = 2'd1,
    MS_RIGHT = 2'd2,
    MS_SPAN  = 2'd3
  } rm_msel_e;

  function automatic logic [XLEN-1:0] rm_rotl(input logic [XLEN-1:0] x,
                                              input logic [SHW-1:0] n);
    logic [2*XLEN-1:0] t;
    t = {x, x} << n;
    return t[2*XLEN-1:XLEN];
  endfunction

  // word mask: ones-from-begin plus sign-filled end term plus wrap correction
  function automatic logic [XLEN-1:0] rm_word_mask(input logic [WSHW-1:0] mb,
                                                   input logic [WSHW-1:0] me);
    logic [XLEN-1:0] lo;
    logic [XLEN-1:0] hi;
    lo = {{WLEN{1'b0}}, {WLEN{1'b1}}} >> mb;
    hi = XLEN'($signed({{WLEN{1'b1}}, 1'b1, {(WLEN-1){1'b0}}}) >>> me);
    return lo + hi + {{(XLEN-1){1'b0}}, (me >= mb)};
  endfunction

  function automatic logic [XLEN-1:0] rm_left_mask(input logic [SHW-1:0] mb);
    return {XLEN{1'b1}} >> mb;
  endfunction

  function automatic logic [XLEN-1:0] rm_right_mask(input logic [SHW-1:0] me);
    return XLEN'($signed({1'b1, {(XLEN-1){1'b0}}}) >>> me);
  endfunction

  function automatic logic [XLEN-1:0] rm_span_mask(input logic [SHW-1:0] mb,
                                                   input logic [SHW-1:0] me);
    return rm_left_mask(mb) + rm_right_mask(me) + {{(XLEN-1){1'b0}}, (me >= mb)};
  endfunction
endpackage

// File: rtl/rm_decode.sv
module rm_decode
  import rm_pkg::*;
(
  input  logic                 dw,
  input  logic [1:0]           kind,
  input  logic [15:0]          fld,
  input  logic [XLEN-1:0]      shreg,
  output logic [SHW-1:0]       sh_amt,
  output logic [SHW-1:0]       mb,
  output logic [SHW-1:0]       me,
  output rm_msel_e             msel,
  output logic                 ins_en,
  output logic                 word_mode,
  output logic                 illegal
);
  logic [1:0] imm_sub;
  logic [2:0] reg_sub;
  logic       unused_bits;

  assign imm_sub     = fld[3:2];
  assign reg_sub     = fld[3:1];
  assign unused_bits = ^{fld[0], fld[4], shreg[XLEN-1:SHW]};
  assign word_mode   = ~dw;

  always_comb begin
    sh_amt  = '0;
    mb      = '0;
    me      = '0;
    msel    = MS_WORD;
    ins_en  = 1'b0;
    illegal = 1'b0;
    if (!dw) begin
      mb      = {1'b0, fld[10:6]};
      me      = {1'b0, fld[5:1]};
      sh_amt  = (kind == RK_REG) ? {1'b0, shreg[WSHW-1:0]} : {1'b0, fld[15:11]};
      ins_en  = (kind == RK_INS);
      illegal = (kind == RK_BAD);
    end else begin
      mb = {fld[5], fld[10:6]};
      unique case (kind)
        RK_IMM: begin
          sh_amt = {fld[1], fld[15:11]};
          me     = 6'(XLEN - 1) - sh_amt;
          unique case (imm_sub)
            2'd0: msel = MS_LEFT;
            2'd1: msel = MS_RIGHT;
            2'd2: msel = MS_SPAN;
            default: begin
              msel   = MS_SPAN;
              ins_en = 1'b1;
            end
          endcase
        end
        RK_REG: begin
          sh_amt = shreg[SHW-1:0];
          if (reg_sub == 3'd0)      msel = MS_LEFT;
          else if (reg_sub == 3'd1) msel = MS_RIGHT;
          else                      illegal = 1'b1;
        end
        default: illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/rm_rotator.sv
module rm_rotator
  import rm_pkg::*;
(
  input  logic            word_mode,
  input  logic [XLEN-1:0] src,
  input  logic [SHW-1:0]  sh_amt,
  output logic [XLEN-1:0] rot
);
  logic [XLEN-1:0] data_in;
  assign data_in = word_mode ? {src[WLEN-1:0], src[WLEN-1:0]} : src;
  assign rot     = rm_rotl(data_in, sh_amt);
endmodule

// File: rtl/rm_masker.sv
module rm_masker
  import rm_pkg::*;
(
  input  rm_msel_e        msel,
  input  logic [SHW-1:0]  mb,
  input  logic [SHW-1:0]  me,
  output logic [XLEN-1:0] mask
);
  always_comb begin
    unique case (msel)
      MS_WORD:  mask = rm_word_mask(mb[WSHW-1:0], me[WSHW-1:0]);
      MS_LEFT:  mask = rm_left_mask(mb);
      MS_RIGHT: mask = rm_right_mask(mb);
      default:  mask = rm_span_mask(mb, me);
    endcase
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rm_pkg::*;
(
  input  logic             dw_i,
  input  logic [1:0]       kind_i,
  input  logic [15:0]      fld_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [XLEN-1:0]  dst_old_i,
  input  logic [XLEN-1:0]  shreg_i,
  output logic [XLEN-1:0]  result_o,
  output logic             illegal_o
);
  logic [SHW-1:0]  sh_w;
  logic [SHW-1:0]  mb_w;
  logic [SHW-1:0]  me_w;
  rm_msel_e        msel_w;
  logic            ins_w;
  logic            word_w;
  logic            ill_w;
  logic [XLEN-1:0] rot_w;
  logic [XLEN-1:0] mask_w;

  rm_decode u_dec (
    .dw(dw_i), .kind(kind_i), .fld(fld_i), .shreg(shreg_i),
    .sh_amt(sh_w), .mb(mb_w), .me(me_w), .msel(msel_w),
    .ins_en(ins_w), .word_mode(word_w), .illegal(ill_w)
  );

  rm_rotator u_rot (
    .word_mode(word_w), .src(src_i), .sh_amt(sh_w), .rot(rot_w)
  );

  rm_masker u_msk (
    .msel(msel_w), .mb(mb_w), .me(me_w), .mask(mask_w)
  );

  always_comb begin
    if (ill_w)      result_o = '0;
    else if (ins_w) result_o = (dst_old_i & ~mask_w) | (rot_w & mask_w);
    else            result_o = rot_w & mask_w;
  end
  assign illegal_o = ill_w;
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk
  import rm_pkg::*;
(
  input logic            dw_i,
  input logic [1:0]      kind_i,
  input logic [XLEN-1:0] src_i,
  input logic [XLEN-1:0] dst_old_i,
  input logic [XLEN-1:0] shreg_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] rot_w,
  input logic [XLEN-1:0] mask_w,
  input logic [SHW-1:0]  sh_w,
  input logic [SHW-1:0]  mb_w,
  input logic [SHW-1:0]  me_w,
  input logic            ins_w,
  input logic            word_w
);
  always_comb begin
    assert_illegal_zero_R9: assert (!illegal_o || result_o == '0)
      else $error("illegal encoding gave nonzero result");
    assert_clear_outside_R1: assert (illegal_o || ins_w || (result_o & ~mask_w) == '0)
      else $error("bits outside mask not cleared");
    assert_insert_keep_R3: assert (illegal_o || !ins_w ||
                                   (result_o & ~mask_w) == (dst_old_i & ~mask_w))
      else $error("insert lost old destination bits");
    assert_inside_rot_R6: assert (illegal_o || (result_o & mask_w) == (rot_w & mask_w))
      else $error("bits inside mask differ from rotation");
    assert_word_dup_R1: assert (!word_w || rot_w[XLEN-1:WLEN] == rot_w[WLEN-1:0])
      else $error("word rotate halves differ");
    assert_span_upper_R2: assert (!word_w || illegal_o || me_w < mb_w ||
                                  mask_w[XLEN-1:WLEN] == '0)
      else $error("contiguous word mask reached upper half");
    assert_zero_rot_R8: assert (sh_w != '0 ||
                                rot_w == (word_w ? {src_i[WLEN-1:0], src_i[WLEN-1:0]} : src_i))
      else $error("zero rotate altered data");
    assert_reg_width_R4: assert (!word_w || kind_i != RK_REG || sh_w == {1'b0, shreg_i[WSHW-1:0]})
      else $error("word register shift used wrong bits");
    assert_dw_reg_width_R7: assert (dw_i == 1'b0 || kind_i != RK_REG || sh_w == shreg_i[SHW-1:0])
      else $error("doubleword register shift used wrong bits");
  end
endmodule

bind rotmask_unit rotmask_unit_chk u_chk (
  .dw_i(dw_i), .kind_i(kind_i), .src_i(src_i), .dst_old_i(dst_old_i),
  .shreg_i(shreg_i), .result_o(result_o), .illegal_o(illegal_o),
  .rot_w(rot_w), .mask_w(mask_w), .sh_w(sh_w), .mb_w(mb_w), .me_w(me_w),
  .ins_w(ins_w), .word_w(word_w)
);

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  localparam int NSWEEP = 300;

  typedef struct packed {
    logic        dw;
    logic [1:0]  kind;
    logic [15:0] fld;
    logic [63:0] src;
    logic [63:0] old;
    logic [63:0] shreg;
    logic        ill;
  } vec_t;

  localparam vec_t TBL [0:NVEC-1] = '{
    '{1'b0, 2'd0, 16'h0000, 64'h0, 64'h0, 64'h0, 1'b0},
    '{1'b0, 2'd1, 16'h403E, 64'h1122334455667788, 64'h0, 64'h0, 1'b0},
    '{1'b0, 2'd1, 16'h0206, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0, 1'b0},
    '{1'b0, 2'd0, 16'h242E, 64'h00000000DEADBEEF, 64'hA5A5A5A5A5A5A5A5, 64'h0, 1'b0},
    '{1'b0, 2'd2, 16'h003E, 64'h0123456789ABCDEF, 64'h0, 64'hFFFFFFFFFFFFFFE3, 1'b0},
    '{1'b0, 2'd1, 16'hF94A, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0, 1'b0},
    '{1'b0, 2'd1, 16'h0040, 64'h0000000012345678, 64'h0, 64'h0, 1'b0},
    '{1'b1, 2'd1, 16'h0000, 64'hCAFEF00D12345678, 64'h0, 64'h0, 1'b0},
    '{1'b1, 2'd1, 16'h2222, 64'h0123456789ABCDEF, 64'h0, 64'h0, 1'b0},
    '{1'b1, 2'd1, 16'h83E4, 64'h0123456789ABCDEF, 64'h0, 64'h0, 1'b0},
    '{1'b1, 2'd1, 16'hA288, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0, 1'b0},
    '{1'b1, 2'd1, 16'h1C2C, 64'h00000000000000F7, 64'h5555555555555555, 64'h0, 1'b0},
    '{1'b1, 2'd1, 16'hA4A8, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0, 1'b0},
    '{1'b1, 2'd2, 16'h0002, 64'h8877665544332211, 64'h0, 64'h00000000000000C5, 1'b0},
    '{1'b1, 2'd2, 16'h0004, 64'h8877665544332211, 64'h0, 64'h0, 1'b1},
    '{1'b1, 2'd0, 16'h0000, 64'h8877665544332211, 64'h0, 64'h0, 1'b1},
    '{1'b0, 2'd3, 16'h403E, 64'h8877665544332211, 64'h0, 64'h0, 1'b1},
    '{1'b1, 2'd2, 16'h00C0, 64'h0F0F0F0F0F0F0F0F, 64'h0, 64'hFFFFFFFFFFFFFF3F, 1'b0}
  };

  logic        clk = 1'b0;
  logic        dw_i = 1'b0;
  logic [1:0]  kind_i = 2'd0;
  logic [15:0] fld_i = 16'h0;
  logic [63:0] src_i = 64'h0;
  logic [63:0] dst_old_i = 64'h0;
  logic [63:0] shreg_i = 64'h0;
  logic [63:0] result_o;
  logic        illegal_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmask_unit dut (
    .dw_i(dw_i), .kind_i(kind_i), .fld_i(fld_i), .src_i(src_i),
    .dst_old_i(dst_old_i), .shreg_i(shreg_i),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  // independent bit-by-bit reference; index p counts from the MSB
  function automatic logic [64:0] model(input logic dw, input logic [1:0] kind,
      input logic [15:0] fld, input logic [63:0] src, input logic [63:0] old,
      input logic [63:0] shreg);
    logic [63:0] rot, m;
    logic [31:0] r32;
    int sh, mb, me, sub;
    bit ill, ins, inm;
    rot = '0; m = '0; r32 = '0; ill = 0; ins = 0; sub = 0;
    if (!dw) begin
      ill = (kind == 2'd3);
      ins = (kind == 2'd0);
      sh = (kind == 2'd2) ? int'(shreg[4:0]) : int'(fld[15:11]);
      mb = int'(fld[10:6]);
      me = int'(fld[5:1]);
      for (int j = 0; j < 32; j++) r32[(j + sh) % 32] = src[j];
      rot = {r32, r32};
      for (int p = 0; p < 64; p++) begin
        if (p < 32) inm = (me < mb);
        else if (mb <= me) inm = (p - 32 >= mb) && (p - 32 <= me);
        else inm = (p - 32 >= mb) || (p - 32 <= me);
        m[63 - p] = inm;
      end
    end else begin
      mb = int'({fld[5], fld[10:6]});
      if (kind == 2'd1) begin
        sh = int'({fld[1], fld[15:11]});
        sub = int'(fld[3:2]);
      end else begin
        sh = int'(shreg[5:0]);
        sub = int'(fld[3:1]);
        if (sub > 1) ill = 1;
      end
      if (kind == 2'd0 || kind == 2'd3) ill = 1;
      ins = (kind == 2'd1) && (sub == 3);
      me = 63 - sh;
      for (int j = 0; j < 64; j++) rot[(j + sh) % 64] = src[j];
      for (int p = 0; p < 64; p++) begin
        if (sub == 0) inm = (p >= mb);
        else if (sub == 1) inm = (p <= mb);
        else if (mb <= me) inm = (p >= mb) && (p <= me);
        else inm = (p >= mb) || (p <= me);
        m[63 - p] = inm;
      end
    end
    if (ill) return {1'b1, 64'h0};
    if (ins) return {1'b0, (old & ~m) | (rot & m)};
    return {1'b0, rot & m};
  endfunction

  task automatic apply(input logic dw, input logic [1:0] kind, input logic [15:0] fld,
                       input logic [63:0] src, input logic [63:0] old, input logic [63:0] shreg);
    @(posedge clk);
    #1;
    dw_i = dw; kind_i = kind; fld_i = fld; src_i = src; dst_old_i = old; shreg_i = shreg;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [63:0] exp_res, input logic exp_ill);
    n_run++;
    if (result_o !== exp_res || illegal_o !== exp_ill) begin
      n_fail++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result_o, illegal_o, exp_res, exp_ill);
    end
  endtask

  initial begin
    logic [64:0] e;
    logic [63:0] x;
    logic [63:0] y;
    // idle state: all-zero inputs give a zero, legal result (R3 insert of zeros)
    @(negedge clk);
    check("R3 idle", 64'h0, 1'b0);
    // table walk: every entry compared with the reference model and its illegal flag
    for (int i = 0; i < NVEC; i++) begin
      apply(TBL[i].dw, TBL[i].kind, TBL[i].fld, TBL[i].src, TBL[i].old, TBL[i].shreg);
      e = model(TBL[i].dw, TBL[i].kind, TBL[i].fld, TBL[i].src, TBL[i].old, TBL[i].shreg);
      if (e[64] !== TBL[i].ill) $display("table entry %0d has inconsistent flag", i);
      check(TBL[i].dw ? (TBL[i].kind == 2'd2 ? "R7 table" : "R6 table") : "R1 table",
            e[63:0], TBL[i].ill);
    end
    // directed corner cases with hand-derived values
    apply(1'b0, 2'd1, 16'h003E, 64'h1122334455667788, 64'h0, 64'h0);
    check("R8 word zero rotate", 64'h0000000055667788, 1'b0);
    apply(1'b0, 2'd1, 16'h403E, 64'h1122334455667788, 64'h0, 64'h0);
    check("R1 word rotate by 8", 64'h0000000066778855, 1'b0);
    apply(1'b0, 2'd1, 16'h0206, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0);
    check("R2 wrapped mask", 64'hFFFFFFFFF0FFFFFF, 1'b0);
    apply(1'b0, 2'd1, 16'h0040, 64'h0000000012345678, 64'h0, 64'h0);
    check("R2 full wrap", 64'h1234567812345678, 1'b0);
    apply(1'b0, 2'd2, 16'h003E, 64'h00000000AABBCCDD, 64'h0, 64'hABCD000000000020);
    check("R4 high shift bits ignored", 64'h00000000AABBCCDD, 1'b0);
    apply(1'b1, 2'd1, 16'h0000, 64'hCAFEF00D12345678, 64'h0, 64'h0);
    check("R8 dw zero rotate", 64'hCAFEF00D12345678, 1'b0);
    apply(1'b1, 2'd1, 16'h0020, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h0);
    check("R5 begin index msb", 64'h00000000FFFFFFFF, 1'b0);
    apply(1'b1, 2'd1, 16'h0002, 64'h0000000000000001, 64'h0, 64'h0);
    check("R5 shift msb", 64'h0000000100000000, 1'b0);
    apply(1'b1, 2'd2, 16'h0008, 64'h1, 64'h0, 64'h0);
    check("R9 dw reg code 4", 64'h0, 1'b1);
    apply(1'b0, 2'd0, 16'h0000, 64'h0, 64'hFFFFFFFF00000000, 64'h0);
    check("R3 insert keeps old", 64'hFFFFFFFF00000000, 1'b0);
    // pseudo-random sweep against the model
    x = 64'h9E3779B97F4A7C15;
    y = 64'hD1B54A32D192ED03;
    for (int i = 0; i < NSWEEP; i++) begin
      x ^= x << 13; x ^= x >> 7; x ^= x << 17;
      y ^= y << 13; y ^= y >> 7; y ^= y << 17;
      apply(x[63], x[62:61], y[15:0], x, y, {y[31:0], x[31:0]});
      e = model(x[63], x[62:61], y[15:0], x, y, {y[31:0], x[31:0]});
      check(x[63] ? "R6 sweep" : "R1 sweep", e[63:0], e[64]);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule